// File: doc/BRIEF.md
# Thread Tag Pool Allocator

This block hands out 8-bit thread tags from a fixed pool and takes them back. Each pool slot pairs a preassigned tag code with a used/free flag. The tag codes are not slot indices: they come from a constant, non-contiguous code table. An allocate request takes the lowest-numbered free slot, marks it used and answers with its tag. A release request carries a tag value, looks it up among the active slots and frees it.

How many slots are active is chosen when the pool is initialised. A dedicated init strobe reloads the pool: every slot becomes free and a new active count is taken from an input. A count outside the allowed range is refused. In that case the default count is used and an error level is raised. Requests come from a single master, one per cycle, and every answer is a registered one-cycle pulse.

Top module: `tsn_pool_alloc`

## Requirements
- R1: During and after a synchronous active-high `rst`, the active count is 28 and every slot is free. `rsp_valid`, `rsp_busy`, `none_free` and `cfg_bad` are all 0.
- R2: The tag of slot i is computed from pair number p = i/2 and the low bit b = i%2:
  - for p < 7 it is 0x04 + 8p + b;
  - for 7 <= p < 14 it is 0x88 + 16(p-7) + b;
  - for 14 <= p < 22 it is 0x08 + 16(p-14) + b;
  - for p = 22 it is 0x80 + b.

  The table has 46 slots, so on a fresh pool successive allocations return 0x04, 0x05, 0x0C, 0x0D and so on.
- R3: `alloc` asserted in a cycle in which an active slot is free produces `rsp_valid` high for exactly the following cycle. In that cycle `rsp_tag` holds the tag of the lowest-index free active slot, and that slot becomes used.
- R4: `alloc` asserted when no active slot is free produces `rsp_busy` high for the following cycle. In that case `rsp_valid` stays low and no slot changes state.
- R5: `rel_req` with `rel_tag` equal to the tag of a used active slot frees that slot from the next cycle on.
- R6: A release whose tag matches no active slot, including the tag of a slot beyond the active count, changes no slot.
- R7: Releasing the tag of a slot that is already free leaves the pool unchanged.
- R8: `init` frees every slot. If `init_count` lies in 28..46 it becomes the active count.
- R9: On `init`, an `init_count` below 28 or above 46 is refused. The active count becomes 28 and `cfg_bad` rises and stays high until the next `init` with a valid count or a reset.
- R10: `init` takes priority over `alloc` and `rel_req` in the same cycle. Neither request has any effect and no response pulse follows.
- R11: `none_free` is high in exactly those cycles in which every active slot is used. It follows the state produced by the previous clock edge.
- R12: `alloc` and `rel_req` in the same cycle both take effect. The slot to allocate is chosen from the state before the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Reinitialise the pool and load the active count |
| init_count | input | 6 | Requested active slot count, sampled on `init` |
| alloc | input | 1 | Allocate request |
| rel_req | input | 1 | Release request |
| rel_tag | input | 8 | Tag to release |
| rsp_valid | output | 1 | One-cycle pulse: allocation succeeded |
| rsp_tag | output | 8 | Allocated tag, meaningful while `rsp_valid` is high |
| rsp_busy | output | 1 | One-cycle pulse: allocation failed, pool exhausted |
| none_free | output | 1 | Level: no active slot is free |
| cfg_bad | output | 1 | Level: the last init request carried an out-of-range count |

## Verification
The hardest state to reach is a fully exhausted pool with holes punched back into it. The stimulus drains every active slot with back-to-back allocations. It then frees slots out of order, repeats releases of the same tag, and releases tags that belong to inactive slots. Only after that does it allocate again, so that the lowest-index choice and the ignore rules show up on `rsp_tag` and `rsp_busy`. The full 46-slot pool is reached through an init with the maximum count. The last-entry tags and the cases where init wins over a request that arrives in the same cycle are driven the same way.

// File: rtl/tsn_pkg.sv
package tsn_pkg;

  localparam int TAG_W     = 8;
  localparam int TABLE_LEN = 46;

  // Preassigned tag code of slot i, generated from its pair number.
  function automatic logic [TAG_W-1:0] slot_tag(input int i);
    int p;
    int b;
    int base;
    p = i / 2;
    b = i % 2;
    if (p < 7)
      base = 'h04 + 8 * p;
    else if (p < 14)
      base = 'h88 + 16 * (p - 7);
    else if (p < 22)
      base = 'h08 + 16 * (p - 14);
    else
      base = 'h80;
    return TAG_W'(base + b);
  endfunction

endpackage

// File: rtl/tsn_tag_rom.sv
module tsn_tag_rom
  import tsn_pkg::*;
#(
  parameter int NUM_SLOTS = 46
) (
  output logic [NUM_SLOTS-1:0][TAG_W-1:0] tags
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign tags[g] = slot_tag(g);
  end

endmodule

// File: rtl/tsn_first_pick.sv
module tsn_first_pick #(
  parameter int W = 46,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req,
  output logic [W-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
    onehot = '0;
    onehot[idx] = any;
  end

endmodule

// File: rtl/tsn_tag_match.sv
module tsn_tag_match
  import tsn_pkg::*;
#(
  parameter int NUM_SLOTS = 46
) (
  input  logic [NUM_SLOTS-1:0][TAG_W-1:0] tags,
  input  logic [NUM_SLOTS-1:0]            active,
  input  logic [TAG_W-1:0]                key,
  output logic [NUM_SLOTS-1:0]            hit
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign hit[g] = active[g] && (tags[g] == key);
  end

endmodule

// File: rtl/tsn_pool_alloc.sv
module tsn_pool_alloc
  import tsn_pkg::*;
#(
  parameter int NUM_SLOTS  = 46,
  parameter int DEF_ACTIVE = 28,
  parameter int MIN_ACTIVE = 28,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1),
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic [CNT_W-1:0] init_count,
  input  logic             alloc,
  input  logic             rel_req,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             rsp_valid,
  output logic [TAG_W-1:0] rsp_tag,
  output logic             rsp_busy,
  output logic             none_free,
  output logic             cfg_bad
);

  logic [NUM_SLOTS-1:0]            used_q, used_n;
  logic [CNT_W-1:0]                cnt_q, cnt_n;
  logic [NUM_SLOTS-1:0]            act_q, act_n;
  logic [NUM_SLOTS-1:0][TAG_W-1:0] tags;
  logic [NUM_SLOTS-1:0]            free_vec, rel_hit;
  logic [NUM_SLOTS-1:0]            pick_oh, rel_oh;
  logic [IDX_W-1:0]                pick_idx, rel_idx;
  logic                            pick_any, rel_any;
  logic                            cnt_ok;

  tsn_tag_rom #(.NUM_SLOTS(NUM_SLOTS)) u_rom (.tags(tags));

  // Active masks for the current and the next count.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_act
    assign act_q[g] = (cnt_q > CNT_W'(g));
    assign act_n[g] = (cnt_n > CNT_W'(g));
  end

  assign free_vec = act_q & ~used_q;

  tsn_first_pick #(.W(NUM_SLOTS)) u_alloc_pick (
    .req(free_vec), .onehot(pick_oh), .idx(pick_idx), .any(pick_any)
  );

  tsn_tag_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .tags(tags), .active(act_q), .key(rel_tag), .hit(rel_hit)
  );

  tsn_first_pick #(.W(NUM_SLOTS)) u_rel_pick (
    .req(rel_hit), .onehot(rel_oh), .idx(rel_idx), .any(rel_any)
  );

  assign cnt_ok = (init_count >= CNT_W'(MIN_ACTIVE)) &&
                  (init_count <= CNT_W'(NUM_SLOTS));

  always_comb begin
    used_n = used_q;
    cnt_n  = cnt_q;
    if (init) begin
      used_n = '0;
      cnt_n  = cnt_ok ? init_count : CNT_W'(DEF_ACTIVE);
    end else begin
      if (rel_req && rel_any)
        used_n = used_n & ~rel_oh;
      if (alloc && pick_any)
        used_n = used_n | pick_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q    <= '0;
      cnt_q     <= CNT_W'(DEF_ACTIVE);
      cfg_bad   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_busy  <= 1'b0;
      rsp_tag   <= '0;
      none_free <= 1'b0;
    end else begin
      used_q    <= used_n;
      cnt_q     <= cnt_n;
      none_free <= ~|(act_n & ~used_n);
      rsp_valid <= !init && alloc && pick_any;
      rsp_busy  <= !init && alloc && !pick_any;
      if (init)
        cfg_bad <= !cnt_ok;
      if (!init && alloc && pick_any)
        rsp_tag <= tags[pick_idx];
    end
  end

endmodule

// File: rtl/tsn_pool_chk.sv
module tsn_pool_chk (
  input logic clk,
  input logic rst,
  input logic init,
  input logic alloc,
  input logic rsp_valid,
  input logic rsp_busy,
  input logic none_free,
  input logic cfg_bad
);

  // R3: a grant needs an allocate request and a free slot one cycle earlier
  p_grant_cause_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(alloc) && !$past(init) && !$past(none_free)));

  // R4: a busy answer needs an allocate request on an exhausted pool
  p_busy_cause_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_busy |-> ($past(alloc) && $past(none_free)));

  // R4: grant and busy never together
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_busy));

  // R10: init silences the responses
  p_init_wins_r10: assert property (@(posedge clk) disable iff (rst)
    init |=> (!rsp_valid && !rsp_busy));

  // R8: right after init every active slot is free
  p_fresh_pool_r8: assert property (@(posedge clk) disable iff (rst)
    init |=> !none_free);

  // R9: the error level only moves on init
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !init |=> $stable(cfg_bad));

endmodule

bind tsn_pool_alloc tsn_pool_chk u_chk (
  .clk(clk), .rst(rst), .init(init), .alloc(alloc),
  .rsp_valid(rsp_valid), .rsp_busy(rsp_busy),
  .none_free(none_free), .cfg_bad(cfg_bad)
);

// File: tb/sim_tsn_pool_alloc.sv
`timescale 1ns/1ps
module sim_tsn_pool_alloc;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init = 1'b0;
  logic [5:0] init_count = '0;
  logic       alloc = 1'b0;
  logic       rel_req = 1'b0;
  logic [7:0] rel_tag = '0;
  logic       rsp_valid, rsp_busy, none_free, cfg_bad;
  logic [7:0] rsp_tag;

  always #5 clk = ~clk;

  tsn_pool_alloc u0 (
    .clk(clk), .rst(rst), .init(init), .init_count(init_count),
    .alloc(alloc), .rel_req(rel_req), .rel_tag(rel_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_busy(rsp_busy),
    .none_free(none_free), .cfg_bad(cfg_bad)
  );

  int errors = 0;
  int checks = 0;

  // Reference model state.
  byte unsigned tt [46] = '{
    8'h04, 8'h05, 8'h0C, 8'h0D, 8'h14, 8'h15, 8'h1C, 8'h1D,
    8'h24, 8'h25, 8'h2C, 8'h2D, 8'h34, 8'h35, 8'h88, 8'h89,
    8'h98, 8'h99, 8'hA8, 8'hA9, 8'hB8, 8'hB9, 8'hC8, 8'hC9,
    8'hD8, 8'hD9, 8'hE8, 8'hE9, 8'h08, 8'h09, 8'h18, 8'h19,
    8'h28, 8'h29, 8'h38, 8'h39, 8'h48, 8'h49, 8'h58, 8'h59,
    8'h68, 8'h69, 8'h78, 8'h79, 8'h80, 8'h81};
  bit m_used [46];
  int m_cnt = 28;
  bit m_bad, m_valid, m_busy, m_none;
  byte unsigned m_tag;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int pick;
    if (rst) begin
      foreach (m_used[i]) m_used[i] = 0;
      m_cnt = 28; m_bad = 0; m_valid = 0; m_busy = 0;
    end else if (init) begin
      foreach (m_used[i]) m_used[i] = 0;
      if (init_count >= 28 && init_count <= 46) begin
        m_cnt = int'(init_count); m_bad = 0;
      end else begin
        m_cnt = 28; m_bad = 1;
      end
      m_valid = 0; m_busy = 0;
    end else begin
      pick = -1;
      for (int i = 0; i < m_cnt; i++)
        if (pick < 0 && !m_used[i]) pick = i;
      if (rel_req)
        for (int i = 0; i < m_cnt; i++)
          if (tt[i] == rel_tag) begin m_used[i] = 0; break; end
      m_valid = alloc && pick >= 0;
      m_busy  = alloc && pick < 0;
      if (m_valid) begin m_used[pick] = 1; m_tag = tt[pick]; end
    end
    m_none = 1;
    for (int i = 0; i < m_cnt; i++) if (!m_used[i]) m_none = 0;
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(req, "rsp_valid", rsp_valid, m_valid);
    chk(req, "rsp_busy", rsp_busy, m_busy);
    chk("R11", "none_free", none_free, m_none);
    chk(req, "cfg_bad", cfg_bad, m_bad);
    if (m_valid) chk(req, "rsp_tag", rsp_tag, m_tag);
    init = 0; alloc = 0; rel_req = 0;
  endtask

  task automatic do_alloc(input string req);
    alloc = 1; cyc(req);
  endtask
  task automatic do_rel(input byte unsigned t, input string req);
    rel_req = 1; rel_tag = t; cyc(req);
  endtask
  task automatic do_init(input int c, input string req);
    init = 1; init_count = 6'(c); cyc(req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc("R1");                        // reset held
    rst = 0;
    cyc("R1");
    // R2 R3: drain the default pool in table order
    for (int i = 0; i < 28; i++) do_alloc("R2");
    do_alloc("R4");                   // exhausted
    do_alloc("R4");
    // R5: free two slots out of order, lowest comes back first
    do_rel(8'h0D, "R5");
    do_rel(8'h05, "R5");
    do_alloc("R3");
    // R6: unknown and inactive tags are ignored
    do_rel(8'h00, "R6");
    do_rel(8'h08, "R6");
    do_rel(8'h81, "R6");
    do_alloc("R6");
    do_alloc("R6");
    // R7: double release of one tag
    do_rel(8'hE9, "R7");
    do_rel(8'hE9, "R7");
    do_alloc("R7");
    do_alloc("R7");
    // R12: allocate and release together on an exhausted pool
    alloc = 1; rel_req = 1; rel_tag = 8'h14; cyc("R12");
    do_alloc("R12");
    do_alloc("R12");
    // R8: full table
    do_init(46, "R8");
    for (int i = 0; i < 46; i++) do_alloc("R8");
    do_alloc("R8");
    // R9: refused counts
    do_init(20, "R9");
    for (int i = 0; i < 29; i++) do_alloc("R9");
    do_rel(8'h08, "R9");
    do_alloc("R9");
    do_init(47, "R9");
    do_alloc("R9");
    do_init(30, "R9");
    for (int i = 0; i < 31; i++) do_alloc("R8");
    // R10: init wins over requests in the same cycle
    init = 1; init_count = 6'd28; alloc = 1; rel_req = 1; rel_tag = 8'h04;
    cyc("R10");
    do_alloc("R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule